// File: doc/BRIEF.md
# Receive descriptor writeback engine

The engine moves received frames into host buffers that a ring of 16-byte descriptors in host memory describes. It reads the current descriptor. If the host has handed it over, the engine takes the buffer address, the buffer size and the link control bits, and then accepts bytes from a simple byte-stream port with end-of-frame and status sideband. Each byte that fits goes to a buffer writer port.

When the frame ends, the engine writes descriptor word 0 back with the stored length, the first/last framing bits and the error flags, and returns ownership to the host. It raises a one-cycle receive interrupt unless that descriptor suppresses it. It then moves to the next descriptor.

If the current descriptor still belongs to the host, the engine drops incoming frames and flags buffer-unavailable until software issues a poll demand. The first poll demand after reset starts the engine at the ring base address.

Top module: `rxd_engine`

## Requirements
- R1: A descriptor is used only when bit 31 of its word 0 is 1. The writeback of word 0 always leaves bit 31 at 0.
- R2: The writeback places the number of bytes stored in the buffer, FCS included, in word 0 bits 29:16.
- R3: Every writeback sets bit 9 (first) and bit 8 (last). Bits 30, 13, 10, 7 and 0 are 0.
- R4: The rx_status sideband is sampled with the final byte. Its bits map to word 0 as follows: [0] CRC error to bit 1, [1] dribble to bit 2, [2] receive error to bit 3, [3] watchdog timeout to bit 4, [4] frame type to bit 5, [5] late collision to bit 6, [6] overflow to bit 11.
- R5: Bit 15 (error summary) is the OR of bits 1, 3, 4, 6, 11, 12 and 14. Dribble and frame type alone leave it 0.
- R6: Bytes beyond the buffer size in word 1 bits 10:0 are discarded, not written. Such a frame sets bit 12 (length error).
- R7: A descriptor whose buffer size is 0 sets bit 14 (descriptor error) on writeback.
- R8: After writeback the engine moves to the next descriptor. If word 1 bit 25 (end of ring) is set, it goes to ring_base; otherwise, if bit 24 (chained) is set, it goes to the address in word 3; otherwise it goes to the current address + 16. End of ring takes priority.
- R9: rx_irq pulses in the writeback cycle unless word 1 bit 31 is set.
- R10: When the fetched descriptor is host-owned, the engine accepts and drops frames with no buffer write and no writeback. It sets rbu_flag at the end of each dropped frame. A poll_demand clears rbu_flag and makes the engine fetch the same descriptor again once no frame is in progress.
- R11: After reset rx_ready, mem_rd, mem_wr and rbu_flag are 0 and stay so until the first poll_demand, which loads ring_base as the current descriptor.
- R12: Stored bytes go to buf_addr = buffer address (word 2) + byte offset, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | AW | Address of the first descriptor in the ring |
| poll_demand | input | 1 | Start, or resume after buffer-unavailable |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of the frame |
| rx_status | input | 7 | Frame status, valid with rx_last |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| mem_rd | output | 1 | Descriptor word read, data returns next cycle |
| mem_wr | output | 1 | Descriptor word 0 writeback |
| mem_addr | output | AW | Byte address of the descriptor word |
| mem_wdata | output | 32 | Writeback word 0 |
| mem_rdata | input | 32 | Read data for the previous cycle's read |
| buf_we | output | 1 | Buffer byte write |
| buf_addr | output | AW | Buffer byte address |
| buf_byte | output | 8 | Buffer byte data |
| buf_base | output | AW | Buffer address of the current descriptor |
| buf_size | output | SZW | Buffer size of the current descriptor |
| rx_irq | output | 1 | Receive completion pulse |
| rbu_flag | output | 1 | Receive buffer unavailable |

## Verification
The bench walks a three-entry ring whose last entry sets both end-of-ring and chained. A design that let the chain pointer win would write its next status word to the wrong address. A frame longer than its buffer checks that exactly the fitting bytes are written and that the length field reports the stored count, not the arrived count. A size-zero descriptor then checks the descriptor-error path, where nothing may be stored.

After the ring wraps onto a descriptor the host has not returned, a dropped frame must produce no buffer write and no writeback, and must raise rbu_flag. The following poll must clear the flag and refetch the same slot. The descriptor with interrupt suppression catches an engine that pulses rx_irq on every writeback.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int LEN_W = 14;

  // word 0 bit positions
  localparam int W0_OWN  = 31;
  localparam int W0_LEN  = 16;
  localparam int W0_ES   = 15;
  localparam int W0_DE   = 14;
  localparam int W0_LE   = 12;
  localparam int W0_OE   = 11;
  localparam int W0_FS   = 9;
  localparam int W0_LS   = 8;
  localparam int W0_LC   = 6;
  localparam int W0_FT   = 5;
  localparam int W0_RWT  = 4;
  localparam int W0_RE   = 3;
  localparam int W0_DBE  = 2;
  localparam int W0_CE   = 1;

  // word 1 bit positions
  localparam int W1_DIC  = 31;
  localparam int W1_EOR  = 25;
  localparam int W1_CHN  = 24;

  // sideband positions
  localparam int SB_CRC  = 0;
  localparam int SB_DRIB = 1;
  localparam int SB_RXE  = 2;
  localparam int SB_WDOG = 3;
  localparam int SB_TYPE = 4;
  localparam int SB_LATE = 5;
  localparam int SB_OVF  = 6;
  localparam int SB_W    = 7;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_CHK0, S_GET1, S_GET2, S_GET3, S_RECV, S_WB, S_SUSP
  } rxd_state_e;

endpackage

// File: rtl/rxd_fill.sv
module rxd_fill
  import rxd_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SZW = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [7:0]       din,
  input  logic [AW-1:0]    base,
  input  logic [SZW-1:0]   size,
  output logic             buf_we,
  output logic [AW-1:0]    buf_addr,
  output logic [7:0]       buf_byte,
  output logic [LEN_W-1:0] len,
  output logic             trunc
);
  localparam int PADW = LEN_W - SZW;

  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic             tr_q, tr_n;
  logic             fits;

  assign fits     = cnt_q < {{PADW{1'b0}}, size};
  assign buf_we   = take && fits;
  assign buf_addr = base + AW'(cnt_q);
  assign buf_byte = din;
  assign len      = cnt_q;
  assign trunc    = tr_q;

  always_comb begin
    cnt_n = cnt_q;
    tr_n  = tr_q;
    if (clr) begin
      cnt_n = '0;
      tr_n  = 1'b0;
    end else if (take) begin
      if (fits) cnt_n = cnt_q + LEN_W'(1);
      else      tr_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tr_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      tr_q  <= tr_n;
    end
  end
endmodule

// File: rtl/rxd_status.sv
module rxd_status
  import rxd_pkg::*;
(
  input  logic [LEN_W-1:0] len,
  input  logic [SB_W-1:0]  sb,
  input  logic             trunc,
  input  logic             derr,
  output logic [31:0]      word
);
  always_comb begin
    word             = '0;
    word[W0_LEN +: LEN_W] = len;
    word[W0_FS]      = 1'b1;
    word[W0_LS]      = 1'b1;
    word[W0_CE]      = sb[SB_CRC];
    word[W0_DBE]     = sb[SB_DRIB];
    word[W0_RE]      = sb[SB_RXE];
    word[W0_RWT]     = sb[SB_WDOG];
    word[W0_FT]      = sb[SB_TYPE];
    word[W0_LC]      = sb[SB_LATE];
    word[W0_OE]      = sb[SB_OVF];
    word[W0_LE]      = trunc;
    word[W0_DE]      = derr;
    word[W0_ES]      = sb[SB_CRC] | sb[SB_RXE] | sb[SB_WDOG] | sb[SB_LATE]
                     | sb[SB_OVF] | trunc | derr;
    word[W0_OWN]     = 1'b0;
  end
endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SZW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   ring_base,
  input  logic            poll_demand,
  input  logic            rx_valid,
  input  logic            rx_last,
  input  logic [SB_W-1:0] rx_status,
  input  logic [31:0]     mem_rdata,
  output logic            rx_ready,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [AW-1:0]   mem_addr,
  output logic            take,
  output logic            clr,
  output logic            rx_irq,
  output logic            rbu_flag,
  output logic [AW-1:0]   bufp,
  output logic [SZW-1:0]  size,
  output logic [SB_W-1:0] sb
);
  rxd_state_e      st_q, st_n;
  logic [AW-1:0]   cur_q, cur_n, nxt_q, nxt_n, bufp_q, bufp_n;
  logic [SZW-1:0]  size_q, size_n;
  logic [SB_W-1:0] sb_q, sb_n;
  logic            dic_q, dic_n, eor_q, eor_n, chn_q, chn_n;
  logic            mid_q, mid_n, pend_q, pend_n, rbu_q, rbu_n;

  assign bufp     = bufp_q;
  assign size     = size_q;
  assign sb       = sb_q;
  assign rbu_flag = rbu_q;

  always_comb begin
    st_n = st_q;   cur_n = cur_q;   nxt_n = nxt_q;  bufp_n = bufp_q;
    size_n = size_q; sb_n = sb_q;   dic_n = dic_q;  eor_n = eor_q;
    chn_n = chn_q; mid_n = mid_q;   pend_n = pend_q; rbu_n = rbu_q;
    mem_rd = 1'b0; mem_wr = 1'b0;   mem_addr = cur_q;
    rx_ready = 1'b0; take = 1'b0;   clr = 1'b0;     rx_irq = 1'b0;
    case (st_q)
      S_IDLE: if (poll_demand) begin
        cur_n = ring_base;
        st_n  = S_RD0;
      end
      S_RD0: begin
        mem_rd = 1'b1;
        st_n   = S_CHK0;
      end
      S_CHK0: begin
        clr = 1'b1;
        if (mem_rdata[W0_OWN]) begin
          mem_rd   = 1'b1;
          mem_addr = cur_q + AW'(4);
          st_n     = S_GET1;
        end else begin
          st_n = S_SUSP;
        end
      end
      S_GET1: begin
        dic_n    = mem_rdata[W1_DIC];
        eor_n    = mem_rdata[W1_EOR];
        chn_n    = mem_rdata[W1_CHN];
        size_n   = mem_rdata[SZW-1:0];
        mem_rd   = 1'b1;
        mem_addr = cur_q + AW'(8);
        st_n     = S_GET2;
      end
      S_GET2: begin
        bufp_n = mem_rdata[AW-1:0];
        if (chn_q) begin
          mem_rd   = 1'b1;
          mem_addr = cur_q + AW'(12);
          st_n     = S_GET3;
        end else begin
          st_n = S_RECV;
        end
      end
      S_GET3: begin
        nxt_n = mem_rdata[AW-1:0];
        st_n  = S_RECV;
      end
      S_RECV: begin
        rx_ready = 1'b1;
        take     = rx_valid;
        if (rx_valid && rx_last) begin
          sb_n = rx_status;
          st_n = S_WB;
        end
      end
      S_WB: begin
        mem_wr = 1'b1;
        rx_irq = !dic_q;
        if (eor_q)      cur_n = ring_base;
        else if (chn_q) cur_n = nxt_q;
        else            cur_n = cur_q + AW'(16);
        st_n = S_RD0;
      end
      S_SUSP: begin
        rx_ready = 1'b1;
        if (rx_valid) mid_n = !rx_last;
        if (rx_valid && rx_last) rbu_n = 1'b1;
        if (poll_demand) begin
          rbu_n  = 1'b0;
          pend_n = 1'b1;
        end
        if ((pend_q || poll_demand) && !mid_n) begin
          pend_n = 1'b0;
          st_n   = S_RD0;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  cur_q <= '0;  nxt_q <= '0;  bufp_q <= '0;
      size_q <= '0;    sb_q <= '0;   dic_q <= 1'b0; eor_q <= 1'b0;
      chn_q <= 1'b0;   mid_q <= 1'b0; pend_q <= 1'b0; rbu_q <= 1'b0;
    end else begin
      st_q <= st_n;    cur_q <= cur_n; nxt_q <= nxt_n; bufp_q <= bufp_n;
      size_q <= size_n; sb_q <= sb_n;  dic_q <= dic_n; eor_q <= eor_n;
      chn_q <= chn_n;  mid_q <= mid_n; pend_q <= pend_n; rbu_q <= rbu_n;
    end
  end
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
  import rxd_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SZW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   ring_base,
  input  logic            poll_demand,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  input  logic            rx_last,
  input  logic [6:0]      rx_status,
  output logic            rx_ready,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  output logic            buf_we,
  output logic [AW-1:0]   buf_addr,
  output logic [7:0]      buf_byte,
  output logic [AW-1:0]   buf_base,
  output logic [SZW-1:0]  buf_size,
  output logic            rx_irq,
  output logic            rbu_flag
);
  logic             take, clr, trunc;
  logic [SB_W-1:0]  sb;
  logic [LEN_W-1:0] len;

  rxd_ctrl #(.AW(AW), .SZW(SZW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll_demand(poll_demand),
    .rx_valid(rx_valid), .rx_last(rx_last), .rx_status(rx_status),
    .mem_rdata(mem_rdata), .rx_ready(rx_ready), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .take(take), .clr(clr), .rx_irq(rx_irq),
    .rbu_flag(rbu_flag), .bufp(buf_base), .size(buf_size), .sb(sb)
  );

  rxd_fill #(.AW(AW), .SZW(SZW)) u_fill (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .din(rx_data),
    .base(buf_base), .size(buf_size), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_byte(buf_byte), .len(len), .trunc(trunc)
  );

  rxd_status u_stat (
    .len(len), .sb(sb), .trunc(trunc), .derr(buf_size == '0), .word(mem_wdata)
  );
endmodule

// File: rtl/rxd_engine_chk.sv
module rxd_engine_chk #(
  parameter int SZW = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic [31:0]    mem_wdata,
  input logic           rx_irq,
  input logic           rbu_flag,
  input logic           buf_we,
  input logic [SZW-1:0] buf_size
);
  a_r9_irq_only_on_wb: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> mem_wr);
  a_r1_own_returned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !mem_wdata[31]);
  a_r3_single_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata[9] && mem_wdata[8]));
  a_r6_len_within_size: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata[29:16] <= 14'(buf_size)));
  a_r5_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && ((mem_wdata & 32'h0000_585A) != 0)) |-> mem_wdata[15]);
  a_r10_no_store_when_unavail: assert property (@(posedge clk) disable iff (!rst_n)
    rbu_flag |-> !buf_we);
  a_r11_one_port_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

bind rxd_engine rxd_engine_chk #(.SZW(SZW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wdata(mem_wdata), .rx_irq(rx_irq), .rbu_flag(rbu_flag),
  .buf_we(buf_we), .buf_size(buf_size)
);

// File: tb/sim_rxd_engine.sv
module sim_rxd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = 32'h0;
  logic        poll_demand = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h0;
  logic        rx_last = 1'b0;
  logic [6:0]  rx_status = 7'h0;
  logic        rx_ready, mem_rd, mem_wr, buf_we, rx_irq, rbu_flag;
  logic [31:0] mem_addr, mem_wdata, buf_addr, buf_base;
  logic [31:0] mem_rdata = 32'h0;
  logic [7:0]  buf_byte;
  logic [10:0] buf_size;

  always #4 clk = ~clk;

  rxd_engine u0 (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll_demand(poll_demand),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_status(rx_status),
    .rx_ready(rx_ready), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_byte(buf_byte), .buf_base(buf_base),
    .buf_size(buf_size), .rx_irq(rx_irq), .rbu_flag(rbu_flag)
  );

  // host memory with a bench-side write port
  logic [31:0] hmem [0:63];
  logic        hw_en = 1'b0;
  logic [31:0] hw_a = 32'h0, hw_d = 32'h0;
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= hmem[mem_addr[7:2]];
    if (mem_wr) hmem[mem_addr[7:2]] <= mem_wdata;
    if (hw_en)  hmem[hw_a[7:2]] <= hw_d;
  end

  typedef struct { logic [31:0] a; logic [31:0] w; logic irq; } wb_t;
  typedef struct { logic [31:0] a; logic [7:0] d; } by_t;
  wb_t wq[$];
  by_t bq[$];
  int  total = 0, bad = 0;
  bit  done = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected word 0 from the requirement bit map (R2, R3, R4, R5, R6, R7)
  function automatic logic [31:0] exp_word(int len, logic [6:0] s, bit tr, bit de);
    logic [31:0] w;
    logic es;
    w = 32'h0;
    w[29:16] = 14'(len);
    w[9] = 1'b1; w[8] = 1'b1;
    w[1] = s[0]; w[2] = s[1]; w[3] = s[2]; w[4] = s[3];
    w[5] = s[4]; w[6] = s[5]; w[11] = s[6]; w[12] = tr; w[14] = de;
    es = s[0] | s[2] | s[3] | s[5] | s[6] | tr | de;
    w[15] = es;
    return w;
  endfunction

  // monitor: scoreboard pops
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr) begin
        if (wq.size() == 0) begin
          chk("R10 unexpected writeback", mem_addr, 32'hFFFF_FFFF);
        end else begin
          wb_t e;
          e = wq.pop_front();
          chk("R8 writeback address", mem_addr, e.a);
          chk("R1,R2,R3,R4,R5 word0", mem_wdata, e.w);
          chk("R9 irq", {31'h0, rx_irq}, {31'h0, e.irq});
        end
      end else if (rx_irq) begin
        chk("R9 irq outside writeback", 32'h1, 32'h0);
      end
      if (buf_we) begin
        if (bq.size() == 0) begin
          chk("R6,R10 unexpected buffer write", buf_addr, 32'hFFFF_FFFF);
        end else begin
          by_t b;
          b = bq.pop_front();
          chk("R12 buffer address", buf_addr, b.a);
          chk("R12 buffer byte", {24'h0, buf_byte}, {24'h0, b.d});
        end
      end
    end
  end

  task automatic host_write(logic [31:0] a, logic [31:0] d);
    @(posedge clk); #1;
    hw_en = 1'b1; hw_a = a; hw_d = d;
    @(posedge clk); #1;
    hw_en = 1'b0;
  endtask

  task automatic poll();
    @(posedge clk); #1; poll_demand = 1'b1;
    @(posedge clk); #1; poll_demand = 1'b0;
  endtask

  // driver: pushes expected bytes (first cap bytes) then sends the frame
  task automatic send_frame(int id, int n, logic [6:0] s, logic [31:0] base, int cap);
    for (int i = 0; i < n; i++)
      if (i < cap) bq.push_back('{base + 32'(i), 8'((id << 4) | i)});
    for (int i = 0; i < n; i++) begin
      bit acc;
      @(posedge clk); #1;
      rx_valid = 1'b1;
      rx_data  = 8'((id << 4) | i);
      rx_last  = (i == n - 1);
      rx_status = (i == n - 1) ? s : 7'h0;
      do begin
        @(negedge clk); acc = rx_ready;
        @(posedge clk);
      end while (!acc);
      #1;
      rx_valid = 1'b0; rx_last = 1'b0;
    end
  endtask

  task automatic wait_drain(string req);
    for (int i = 0; i < 300 && (wq.size() != 0 || bq.size() != 0); i++)
      @(negedge clk);
    chk(req, 32'(wq.size() + bq.size()), 32'h0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11: quiet after reset until a poll
    repeat (5) @(negedge clk);
    chk("R11 rx_ready", {31'h0, rx_ready}, 32'h0);
    chk("R11 mem_rd", {31'h0, mem_rd}, 32'h0);
    chk("R11 mem_wr", {31'h0, mem_wr}, 32'h0);
    chk("R11 rbu_flag", {31'h0, rbu_flag}, 32'h0);

    // ring: 0x00 chained to 0x20; 0x20 plain (next 0x30, no irq);
    // 0x30 end-of-ring plus chained (end of ring must win, R8)
    host_write(32'h00, 32'h8000_0000);
    host_write(32'h04, (32'h1 << 24) | 32'd8);
    host_write(32'h08, 32'h100);
    host_write(32'h0C, 32'h20);
    host_write(32'h20, 32'h8000_0000);
    host_write(32'h24, (32'h1 << 31) | 32'd64);
    host_write(32'h28, 32'h140);
    host_write(32'h2C, 32'h0);
    host_write(32'h30, 32'h8000_0000);
    host_write(32'h34, (32'h1 << 25) | (32'h1 << 24) | 32'd4);
    host_write(32'h38, 32'h180);
    host_write(32'h3C, 32'h10);
    poll();

    // frame A: CRC error, fits (R4, R5, R12)
    wq.push_back('{32'h00, exp_word(6, 7'h01, 1'b0, 1'b0), 1'b1});
    send_frame(1, 6, 7'h01, 32'h100, 8);
    wait_drain("R2 frame A drained");

    // frame B: frame type plus dribble, no summary, irq suppressed (R5, R9)
    wq.push_back('{32'h20, exp_word(10, 7'h12, 1'b0, 1'b0), 1'b0});
    send_frame(2, 10, 7'h12, 32'h140, 64);
    wait_drain("R9 frame B drained");

    // frame C: longer than buffer, truncated (R6)
    wq.push_back('{32'h30, exp_word(4, 7'h00, 1'b1, 1'b0), 1'b1});
    send_frame(3, 7, 7'h00, 32'h180, 4);
    wait_drain("R6 frame C drained");

    // wrap to 0x00, which the host has not returned: frame D dropped (R10)
    send_frame(4, 5, 7'h04, 32'h0, 0);
    repeat (4) @(negedge clk);
    chk("R10 rbu set", {31'h0, rbu_flag}, 32'h1);
    chk("R10 nothing stored", 32'(wq.size() + bq.size()), 32'h0);

    // re-arm 0x00 with size zero, poll (R7, R10)
    host_write(32'h04, (32'h1 << 24) | 32'd0);
    host_write(32'h00, 32'h8000_0000);
    poll();
    @(negedge clk);
    chk("R10 rbu cleared by poll", {31'h0, rbu_flag}, 32'h0);
    wq.push_back('{32'h00, exp_word(0, 7'h6C, 1'b1, 1'b1), 1'b1});
    send_frame(5, 3, 7'h6C, 32'h100, 0);
    wait_drain("R7 frame E drained");
    repeat (10) @(negedge clk);
    chk("R1 stale slot leaves engine waiting", {31'h0, mem_wr}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule